// File: doc/BRIEF.md
# Ring-Queue Packet Processor with Dependency Barriers

This block takes fixed-size command packets from a ring queue held in an internal array and carries each one through three phases. In launch, an acquire-fence pulse is issued. In active, a dispatch packet is handed to an execution port, while a barrier packet watches a set of dependency signals. In completion, a release-fence pulse is issued and the packet's completion signal is decremented. A host appends packets through a single write port, and each write advances the write index. The read index advances once a packet has fully completed, and the queue is empty when the two indices are equal.

Dispatch packets may overlap: a later dispatch can launch while earlier ones are still executing, unless its header asks for the queue to drain first. Barrier packets block all later launches until their AND or OR condition over a group of small internal signal registers is met. An unsupported header stops the processor and raises a sticky fault. Fences and execution are modelled as pulses and a done strobe.

Top module: `pktq_proc`

## Requirements
- R1: A host write stores the packet at the write index and increments `wr_index`. A write is ignored while `DEPTH` packets are unretired, meaning `wr_index - rd_index == DEPTH`.
- R2: A packet's launch is a one-cycle `acq_pulse` carrying header bits [10:9] on `acq_scope`. For a dispatch packet, `exec_start` follows in the next cycle with `exec_arg` equal to packet bits [63:32].
- R3: The format code sits in header bits [7:0]. Code 2 dispatches with `exec_kind`=0, code 4 dispatches with `exec_kind`=1, code 3 is an AND barrier and code 5 is an OR barrier. Any other code sets `fault`, and `fault` stays set until reset with no further launch.
- R4: For code 4, a function type in `exec_arg[15:0]` below 0x8000 sets `fault` instead of dispatching. Types from 0x8000 to 0xFFFF dispatch.
- R5: A dispatch whose header bit 8 is clear launches without waiting for earlier dispatches to finish.
- R6: A packet whose header bit 8 is set does not launch until every earlier packet has completed, that is, until `rd_index` equals its own position.
- R7: An AND barrier completes only when every valid dependency holds zero. Dependency i is the 4-bit reference at packet bits [32+4i +: 4], with bit 3 meaning valid and bits [2:0] giving the signal index, for i = 0 to 3.
- R8: An OR barrier completes when any valid dependency holds zero, or at once if none is valid. References with bit 3 clear are ignored.
- R9: While a barrier packet has not completed, no later packet launches.
- R10: Completion is a one-cycle `rel_pulse` carrying header bits [12:11] on `rel_scope`. In the next cycle the signal named by the reference in bits [19:16] is decremented, with wrap from 0 to 0xFFFF, and `rd_index` advances by one. A reference whose bit 19 is clear decrements nothing.
- R11: `exec_done` strobes retire dispatches in launch order.
- R12: The signal registers reset to zero. The host writes them with `sig_we`/`sig_wsel`/`sig_wval`, and they read combinationally on `sig_rval` through `sig_rsel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Append a packet to the ring |
| host_pkt | input | 64 | Packet to append |
| sig_we | input | 1 | Signal register write strobe |
| sig_wsel | input | 3 | Signal register written |
| sig_wval | input | 16 | Value written |
| sig_rsel | input | 3 | Signal register observed |
| sig_rval | output | 16 | Value of the observed signal |
| exec_start | output | 1 | Dispatch handed to the execution port |
| exec_kind | output | 1 | 0 kernel, 1 agent function |
| exec_arg | output | 32 | Dispatch payload |
| exec_done | input | 1 | Oldest running dispatch finished |
| acq_pulse | output | 1 | Acquire fence at launch |
| acq_scope | output | 2 | Scope of that fence |
| rel_pulse | output | 1 | Release fence at completion |
| rel_scope | output | 2 | Scope of that fence |
| rd_index | output | 3 | Retire index |
| wr_index | output | 3 | Write index |
| fault | output | 1 | Unsupported packet seen, processing halted |

## Verification
A wrong launch pointer shows up within a few cycles as a missing or duplicated `exec_start`, or as an `exec_arg` belonging to another packet. A wrong retire pointer or completion state shows up as a `rel_pulse` without a matching `rd_index` step, or as the wrong signal being decremented. A barrier evaluation fault appears as `rd_index` moving while a dependency is still nonzero, or staying put after the last one reaches zero. The same fault also shows as a trailing dispatch launching too early or never.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
   // header field positions (neighbours decode these)
   localparam int FMT_LSB  = 0;
   localparam int FMT_W    = 8;
   localparam int BAR_BIT  = 8;
   localparam int ACQ_LSB  = 9;
   localparam int REL_LSB  = 11;
   localparam int SCOPE_W  = 2;
   localparam int CREF_LSB = 16;
   localparam int PAY_LSB  = 32;

   localparam logic [FMT_W-1:0] FMT_KERNEL = 8'd2;
   localparam logic [FMT_W-1:0] FMT_AND    = 8'd3;
   localparam logic [FMT_W-1:0] FMT_AGENT  = 8'd4;
   localparam logic [FMT_W-1:0] FMT_OR     = 8'd5;

   typedef enum logic [2:0] {
      LS_IDLE, LS_ACQ, LS_ACT, LS_HOLD, LS_ERR
   } launch_st_t;

   typedef enum logic [1:0] {
      CS_IDLE, CS_REL, CS_DEC
   } cmpl_st_t;
endpackage

// File: rtl/qpp_ring.sv
module qpp_ring #(
   parameter int DEPTH = 4,
   parameter int PKT_W = 64,
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [PKT_W-1:0] host_pkt,
   input  logic [PTR_W-1:0] lp,
   input  logic [PTR_W-1:0] rp,
   output logic [PTR_W-1:0] wp,
   output logic [PKT_W-1:0] lpkt,
   output logic [PKT_W-1:0] cpkt
);
   localparam int AW = PTR_W - 1;
   localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

   logic [PKT_W-1:0] mem [DEPTH];
   logic             full;
   logic             do_wr;

   assign full  = (wp - rp) == DEPTH_P;
   assign do_wr = host_we && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
      end else if (do_wr) begin
         wp <= wp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) begin
         mem[wp[AW-1:0]] <= host_pkt;
      end
   end

   assign lpkt = mem[lp[AW-1:0]];
   assign cpkt = mem[rp[AW-1:0]];
endmodule

// File: rtl/qpp_sigfile.sv
module qpp_sigfile #(
   parameter int SIG_AW = 3,
   parameter int SIG_W  = 16,
   parameter int SIG_N  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [SIG_AW-1:0]            wr_idx,
   input  logic [SIG_W-1:0]             wr_val,
   input  logic                         dec_en,
   input  logic [SIG_AW-1:0]            dec_idx,
   input  logic [SIG_AW-1:0]            rsel,
   output logic [SIG_W-1:0]             rval,
   output logic [SIG_N-1:0][SIG_W-1:0]  sig_all
);
   for (genvar i = 0; i < SIG_N; i++) begin : g_sig
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sig_all[i] <= '0;
         end else if (wr_en && (wr_idx == SIG_AW'(i))) begin
            sig_all[i] <= wr_val;          // host write wins a collision
         end else if (dec_en && (dec_idx == SIG_AW'(i))) begin
            sig_all[i] <= sig_all[i] - 1'b1;
         end
      end
   end

   assign rval = sig_all[rsel];
endmodule

// File: rtl/qpp_launch.sv
module qpp_launch
   import qpp_pkg::*;
#(
   parameter int PKT_W = 64,
   parameter int PTR_W = 3,
   parameter int ARG_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PTR_W-1:0]   wp,
   input  logic [PTR_W-1:0]   rp,
   input  logic [PKT_W-1:0]   lpkt,
   output logic [PTR_W-1:0]   lp,
   output logic               acq_pulse,
   output logic [SCOPE_W-1:0] acq_scope,
   output logic               exec_start,
   output logic               exec_kind,
   output logic [ARG_W-1:0]   exec_arg,
   output logic               fault
);
   launch_st_t       st, st_n;
   logic [PTR_W-1:0] lp_n;
   logic [FMT_W-1:0] fmt;
   logic [ARG_W-1:0] pay;
   logic             is_disp, is_bar, bad;
   logic             unused_l;

   assign fmt     = lpkt[FMT_LSB +: FMT_W];
   assign pay     = lpkt[PAY_LSB +: ARG_W];
   assign is_disp = (fmt == FMT_KERNEL) || (fmt == FMT_AGENT);
   assign is_bar  = (fmt == FMT_AND) || (fmt == FMT_OR);
   assign bad     = !(is_disp || is_bar) || ((fmt == FMT_AGENT) && !pay[15]);
   assign unused_l = ^lpkt;

   always_comb begin
      st_n = st;
      lp_n = lp;
      unique case (st)
         LS_IDLE: begin
            if (lp != wp) begin
               if (bad) begin
                  st_n = LS_ERR;
               end else if (!lpkt[BAR_BIT] || (rp == lp)) begin
                  st_n = LS_ACQ;
               end
            end
         end
         LS_ACQ:  st_n = LS_ACT;
         LS_ACT: begin
            lp_n = lp + 1'b1;
            st_n = is_bar ? LS_HOLD : LS_IDLE;
         end
         LS_HOLD: if (rp == lp) st_n = LS_IDLE;
         default: st_n = LS_ERR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= LS_IDLE;
         lp <= '0;
      end else begin
         st <= st_n;
         lp <= lp_n;
      end
   end

   assign acq_pulse  = (st == LS_ACQ);
   assign acq_scope  = lpkt[ACQ_LSB +: SCOPE_W];
   assign exec_start = (st == LS_ACT) && is_disp;
   assign exec_kind  = (fmt == FMT_AGENT);
   assign exec_arg   = pay;
   assign fault      = (st == LS_ERR);
endmodule

// File: rtl/qpp_complete.sv
module qpp_complete
   import qpp_pkg::*;
#(
   parameter int PKT_W  = 64,
   parameter int PTR_W  = 3,
   parameter int ARG_W  = 32,
   parameter int SIG_AW = 3,
   parameter int SIG_W  = 16,
   parameter int SIG_N  = 8,
   parameter int NDEP   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PTR_W-1:0]            lp,
   input  logic [PKT_W-1:0]            cpkt,
   input  logic [SIG_N-1:0][SIG_W-1:0] sig_all,
   input  logic                        exec_done,
   output logic [PTR_W-1:0]            rp,
   output logic                        rel_pulse,
   output logic [SCOPE_W-1:0]          rel_scope,
   output logic                        dec_en,
   output logic [SIG_AW-1:0]           dec_idx
);
   localparam int SREF_W = SIG_AW + 1;
   localparam int CR_W   = PTR_W + 1;

   cmpl_st_t          st, st_n;
   logic [CR_W-1:0]   credits;
   logic [FMT_W-1:0]  fmt;
   logic [ARG_W-1:0]  pay;
   logic [SREF_W-1:0] cref;
   logic [NDEP-1:0]   dvld, dzero;
   logic              is_disp, and_ok, or_ok, ready, consume;
   logic              unused_c;

   assign fmt     = cpkt[FMT_LSB +: FMT_W];
   assign pay     = cpkt[PAY_LSB +: ARG_W];
   assign cref    = cpkt[CREF_LSB +: SREF_W];
   assign is_disp = (fmt == FMT_KERNEL) || (fmt == FMT_AGENT);
   assign unused_c = ^cpkt;

   for (genvar i = 0; i < NDEP; i++) begin : g_dep
      logic [SREF_W-1:0] dref;
      assign dref     = pay[i*SREF_W +: SREF_W];
      assign dvld[i]  = dref[SREF_W-1];
      assign dzero[i] = dref[SREF_W-1] && (sig_all[dref[SIG_AW-1:0]] == '0);
   end

   assign and_ok = &(~dvld | dzero);
   assign or_ok  = (|dzero) || !(|dvld);
   assign ready  = is_disp ? (credits != '0)
                           : ((fmt == FMT_AND) ? and_ok : or_ok);

   always_comb begin
      st_n = st;
      unique case (st)
         CS_IDLE: if ((rp != lp) && ready) st_n = CS_REL;
         CS_REL:  st_n = CS_DEC;
         default: st_n = CS_IDLE;
      endcase
   end

   assign consume = (st == CS_DEC) && is_disp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= CS_IDLE;
         rp      <= '0;
         credits <= '0;
      end else begin
         st      <= st_n;
         credits <= credits + CR_W'(exec_done) - CR_W'(consume);
         if (st == CS_DEC) rp <= rp + 1'b1;
      end
   end

   assign rel_pulse = (st == CS_REL);
   assign rel_scope = cpkt[REL_LSB +: SCOPE_W];
   assign dec_en    = (st == CS_DEC) && cref[SREF_W-1];
   assign dec_idx   = cref[SIG_AW-1:0];
endmodule

// File: rtl/pktq_proc.sv
module pktq_proc #(
   parameter  int DEPTH  = 4,
   parameter  int SIG_AW = 3,
   parameter  int SIG_W  = 16,
   parameter  int NDEP   = 4,
   parameter  int ARG_W  = 32,
   localparam int PTR_W  = $clog2(DEPTH) + 1,
   localparam int PKT_W  = qpp_pkg::PAY_LSB + ARG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [PKT_W-1:0]  host_pkt,
   input  logic              sig_we,
   input  logic [SIG_AW-1:0] sig_wsel,
   input  logic [SIG_W-1:0]  sig_wval,
   input  logic [SIG_AW-1:0] sig_rsel,
   output logic [SIG_W-1:0]  sig_rval,
   output logic              exec_start,
   output logic              exec_kind,
   output logic [ARG_W-1:0]  exec_arg,
   input  logic              exec_done,
   output logic              acq_pulse,
   output logic [1:0]        acq_scope,
   output logic              rel_pulse,
   output logic [1:0]        rel_scope,
   output logic [PTR_W-1:0]  rd_index,
   output logic [PTR_W-1:0]  wr_index,
   output logic              fault
);
   localparam int SIG_N  = 1 << SIG_AW;
   localparam int SREF_W = SIG_AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (SREF_W > qpp_pkg::PAY_LSB - qpp_pkg::CREF_LSB) begin : g_bad_sref
      $error("signal reference does not fit its header field");
   end
   if (ARG_W < 16 || NDEP * SREF_W > ARG_W) begin : g_bad_arg
      $error("payload too narrow for function type or dependencies");
   end

   logic [PTR_W-1:0]            lp, rp, wp;
   logic [PKT_W-1:0]            lpkt, cpkt;
   logic [SIG_N-1:0][SIG_W-1:0] sig_all;
   logic                        dec_en;
   logic [SIG_AW-1:0]           dec_idx;

   qpp_ring #(.DEPTH(DEPTH), .PKT_W(PKT_W), .PTR_W(PTR_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_pkt(host_pkt),
      .lp(lp), .rp(rp), .wp(wp), .lpkt(lpkt), .cpkt(cpkt)
   );

   qpp_sigfile #(.SIG_AW(SIG_AW), .SIG_W(SIG_W), .SIG_N(SIG_N)) u_sig (
      .clk(clk), .rst_n(rst_n), .wr_en(sig_we), .wr_idx(sig_wsel),
      .wr_val(sig_wval), .dec_en(dec_en), .dec_idx(dec_idx),
      .rsel(sig_rsel), .rval(sig_rval), .sig_all(sig_all)
   );

   qpp_launch #(.PKT_W(PKT_W), .PTR_W(PTR_W), .ARG_W(ARG_W)) u_launch (
      .clk(clk), .rst_n(rst_n), .wp(wp), .rp(rp), .lpkt(lpkt), .lp(lp),
      .acq_pulse(acq_pulse), .acq_scope(acq_scope),
      .exec_start(exec_start), .exec_kind(exec_kind),
      .exec_arg(exec_arg), .fault(fault)
   );

   qpp_complete #(
      .PKT_W(PKT_W), .PTR_W(PTR_W), .ARG_W(ARG_W), .SIG_AW(SIG_AW),
      .SIG_W(SIG_W), .SIG_N(SIG_N), .NDEP(NDEP)
   ) u_cmpl (
      .clk(clk), .rst_n(rst_n), .lp(lp), .cpkt(cpkt), .sig_all(sig_all),
      .exec_done(exec_done), .rp(rp), .rel_pulse(rel_pulse),
      .rel_scope(rel_scope), .dec_en(dec_en), .dec_idx(dec_idx)
   );

   assign rd_index = rp;
   assign wr_index = wp;
endmodule

// File: rtl/qpp_chk.sv
module qpp_chk #(
   parameter int DEPTH = 4,
   parameter int PTR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acq_pulse,
   input logic             exec_start,
   input logic             rel_pulse,
   input logic             fault,
   input logic [PTR_W-1:0] rd_index,
   input logic [PTR_W-1:0] wr_index
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (PTR_W'(wr_index - rd_index) <= PTR_W'(DEPTH)));                          // R1
   AST_ACQ_LEADS_START: assert property (@(posedge clk) disable iff (!rst_n)
      exec_start |-> $past(acq_pulse));                                          // R2
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);                                                          // R3
   AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!acq_pulse && !exec_start));                                    // R3
   AST_RETIRE_AFTER_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_index != $past(rd_index)) |->
         ((rd_index == PTR_W'($past(rd_index) + 1'b1)) && $past(rel_pulse, 2))); // R10
endmodule

bind pktq_proc qpp_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_qpp_chk (
   .clk(clk), .rst_n(rst_n), .acq_pulse(acq_pulse), .exec_start(exec_start),
   .rel_pulse(rel_pulse), .fault(fault), .rd_index(rd_index), .wr_index(wr_index)
);

// File: tb/tb_pktq_proc.sv
module tb_pktq_proc;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        host_we = 0;
   logic [63:0] host_pkt = '0;
   logic        sig_we = 0;
   logic [2:0]  sig_wsel = '0;
   logic [15:0] sig_wval = '0;
   logic [2:0]  sig_rsel = '0;
   logic [15:0] sig_rval;
   logic        exec_start, exec_kind;
   logic [31:0] exec_arg;
   logic        exec_done = 0;
   logic        acq_pulse, rel_pulse;
   logic [1:0]  acq_scope, rel_scope;
   logic [2:0]  rd_index, wr_index;
   logic        fault;

   int vectors = 0;
   int fails   = 0;
   bit finished = 0;

   int n_acq, n_start, n_rel, ev_n;
   int last_acq, last_rel, last_kind;
   logic [31:0] last_arg;
   int ev_log [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   pktq_proc dut (.*);

   // event monitor, away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         n_acq = 0; n_start = 0; n_rel = 0; ev_n = 0;
         last_acq = 0; last_rel = 0; last_kind = 0; last_arg = '0;
      end else begin
         if (acq_pulse) begin
            n_acq++; last_acq = acq_scope;
            if (ev_n < 16) ev_log[ev_n] = 1;
            ev_n++;
         end
         if (exec_start) begin
            n_start++; last_arg = exec_arg; last_kind = exec_kind;
            if (ev_n < 16) ev_log[ev_n] = 2;
            ev_n++;
         end
         if (rel_pulse) begin
            n_rel++; last_rel = rel_scope;
            if (ev_n < 16) ev_log[ev_n] = 3;
            ev_n++;
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      cyc(3); rst_n = 1; cyc(1);
   endtask

   task automatic push(input logic [63:0] p);
      @(negedge clk); host_we = 1; host_pkt = p;
      @(negedge clk); host_we = 0;
   endtask

   task automatic set_sig(input int i, input int v);
      @(negedge clk); sig_we = 1; sig_wsel = 3'(i); sig_wval = 16'(v);
      @(negedge clk); sig_we = 0;
   endtask

   task automatic get_sig(input int i, output int v);
      sig_rsel = 3'(i); #1; v = sig_rval;
   endtask

   task automatic done_pulse();
      @(negedge clk); exec_done = 1;
      @(negedge clk); exec_done = 0;
   endtask

   function automatic logic [63:0] mk(input int f, input bit bar, input int aq,
                                      input int rl, input logic [3:0] cref,
                                      input logic [31:0] pay);
      logic [63:0] p = '0;
      p[7:0] = 8'(f); p[8] = bar; p[10:9] = 2'(aq); p[12:11] = 2'(rl);
      p[19:16] = cref; p[63:32] = pay;
      return p;
   endfunction

   initial begin
      int v;
      // reset state
      do_reset();
      chk("R1 reset rd_index", rd_index, 0);
      chk("R1 reset wr_index", wr_index, 0);
      chk("R3 reset fault", fault, 0);
      get_sig(3, v); chk("R12 signal reset", v, 0);

      // kernel dispatch through all three phases
      set_sig(1, 5);
      get_sig(1, v); chk("R12 signal write", v, 5);
      push(mk(2, 0, 2, 3, 4'b1001, 32'hDEADBEEF));
      cyc(6);
      chk("R1 wr_index after push", wr_index, 1);
      chk("R2 one acquire", n_acq, 1);
      chk("R2 acquire scope", last_acq, 2);
      chk("R2 one start", n_start, 1);
      chk("R2 start arg", last_arg, 32'hDEADBEEF);
      chk("R3 kernel kind", last_kind, 0);
      chk("R2 acquire before start", ev_log[0] * 10 + ev_log[1], 12);
      chk("R10 no release before done", n_rel, 0);
      chk("R10 rd_index held", rd_index, 0);
      done_pulse(); cyc(6);
      chk("R10 release count", n_rel, 1);
      chk("R10 release scope", last_rel, 3);
      get_sig(1, v); chk("R10 completion decrement", v, 4);
      chk("R10 rd_index step", rd_index, 1);

      // format sweep
      for (int k = 0; k < 9; k++) begin
         int f = (k == 8) ? 255 : k;
         bit good = (f >= 2 && f <= 5);
         bit disp = (f == 2 || f == 4);
         do_reset();
         push(mk(f, 0, 1, 1, 4'b0000, 32'h0000_8000));
         cyc(8);
         chk($sformatf("R3 fault for format %0d", f), fault, !good);
         chk($sformatf("R3 start for format %0d", f), n_start, disp);
         if (disp) chk($sformatf("R3 kind for format %0d", f), last_kind, f == 4);
         chk($sformatf("R8 retire for format %0d", f), rd_index, (f == 3 || f == 5));
         get_sig(0, v); chk($sformatf("R10 null ref format %0d", f), v, 0);
      end

      // agent function type sweep
      for (int k = 0; k < 4; k++) begin
         int t = (k == 0) ? 0 : (k == 1) ? 16'h7FFF : (k == 2) ? 16'h8000 : 16'hFFFF;
         do_reset();
         push(mk(4, 0, 0, 0, 4'b0000, 32'(t)));
         cyc(8);
         chk($sformatf("R4 fault type %0h", t), fault, t < 16'h8000);
         chk($sformatf("R4 start type %0h", t), n_start, t >= 16'h8000);
      end

      // overlap, header barrier flag, in-order retire
      do_reset();
      set_sig(2, 10); set_sig(3, 10); set_sig(4, 10);
      push(mk(2, 0, 0, 0, 4'hA, 32'd1));
      push(mk(2, 0, 0, 0, 4'hB, 32'd2));
      push(mk(2, 1, 0, 0, 4'hC, 32'd3));
      cyc(10);
      chk("R5 two dispatches overlap", n_start, 2);
      chk("R6 flagged packet waits", n_start, 2);
      done_pulse(); cyc(8);
      get_sig(2, v); chk("R11 first retire sig2", v, 9);
      get_sig(3, v); chk("R11 second untouched sig3", v, 10);
      chk("R6 still waiting after one", n_start, 2);
      chk("R10 rd after one", rd_index, 1);
      done_pulse(); cyc(8);
      chk("R6 flagged launches after drain", n_start, 3);
      chk("R6 flagged arg", last_arg, 3);
      done_pulse(); cyc(8);
      get_sig(4, v); chk("R11 third retire sig4", v, 9);
      chk("R10 rd after three", rd_index, 3);

      // AND barrier
      do_reset();
      set_sig(1, 1); set_sig(2, 1);
      push(mk(3, 0, 0, 2, 4'b1101, {16'h0, 4'b0000, 4'b0000, 4'b1010, 4'b1001}));
      push(mk(2, 0, 0, 0, 4'b0000, 32'h77));
      cyc(8);
      chk("R7 AND holds with both set", rd_index, 0);
      chk("R9 blocked behind barrier", n_start, 0);
      set_sig(1, 0); cyc(8);
      chk("R7 AND holds with one set", rd_index, 0);
      chk("R9 still blocked", n_start, 0);
      set_sig(2, 0); cyc(8);
      chk("R7 AND completes", rd_index, 1);
      chk("R10 barrier release scope", last_rel, 2);
      get_sig(5, v); chk("R10 decrement wraps", v, 16'hFFFF);
      chk("R9 launch after barrier", n_start, 1);
      chk("R9 trailing arg", last_arg, 32'h77);

      // OR barrier with a null reference pointing at a zero signal
      do_reset();
      set_sig(1, 1); set_sig(2, 1);
      push(mk(5, 0, 0, 0, 4'b1110, {16'h0, 4'b0000, 4'b0000, 4'b1010, 4'b1001}));
      cyc(8);
      chk("R8 OR holds, null ignored", rd_index, 0);
      set_sig(2, 0); cyc(8);
      chk("R8 OR completes", rd_index, 1);
      get_sig(6, v); chk("R10 OR completion signal", v, 16'hFFFF);

      // full ring
      do_reset();
      for (int k = 0; k < 5; k++) push(mk(2, 0, 0, 0, 4'b0000, 32'(k)));
      cyc(10);
      chk("R1 write ignored when full", wr_index, 4);
      chk("R5 all four launched", n_start, 4);
      done_pulse(); cyc(6);
      chk("R10 one retired", rd_index, 1);
      get_sig(0, v); chk("R10 null ref leaves sig0", v, 0);
      push(mk(2, 0, 0, 0, 4'b0000, 32'd9));
      chk("R1 write accepted after retire", wr_index, 5);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
         $finish;
      end
   end
endmodule